// File: doc/BRIEF.md
# Operand-Width-Aware Dual-Slot Integer ALU

This is a 32-bit integer unit for add, subtract, AND, OR and XOR. On every operation it checks whether each operand is narrow, meaning the upper half holds nothing but copies of the sign. When both operands of an unpacked operation are narrow, the upper sixteen bits of the datapath stop switching. Registers in front of that half keep their previous contents. The upper result bits are then rebuilt from the lower half, with the extra sign bit coming from a signed overflow check at bit 15.

With packing turned on, the one datapath serves two independent sixteen-bit operations that share an opcode. Slot 0 uses the low half and slot 1 uses the high half. The carry chain is cut between the two halves. Each slot's result is sign-extended to 32 bits on its own output.

A packed slot whose operands are not narrow, or whose result does not fit in sixteen signed bits, reports itself not-valid. The issuing logic must then reissue that operation unpacked. Both modes return their results one clock after issue.

Top module: `narrow_alu`

## Requirements
- R1: While reset is asserted and directly after it, both results are zero and the valid and narrow flags are low.
- R2: An operand counts as narrow when its bits 31 down to 15 are all equal. One cycle after issue, `nar0_o` is high exactly when slot 0 was issued and both of its operands are narrow. `nar1_o` is high exactly when packing was on, slot 1 was issued and both of its operands are narrow.
- R3: With `pack_en` low and slot 0 issued with a legal opcode, `res0_o` one cycle later is the 32-bit wrapping result of `a0` op `b0` and `vld0_o` is high. The opcodes are 0 add, 1 subtract (a0 minus b0), 2 AND, 3 OR and 4 XOR. The result is the same whether or not the operands are narrow.
- R4: When an unpacked issue has two narrow slot-0 operands, the registers that feed the upper-half datapath keep their values across that cycle. The result stays exact, including a carry or borrow into bit 16.
- R5: With `pack_en` high, each issued slot loads the sign extension of the sixteen-bit result of its own low operand halves. Slot 0 uses `a0`,`b0` and slot 1 uses `a1`,`b1`. No carry passes between the slots.
- R6: In packed mode a slot's valid output is high only when that slot was issued, both of its operands are narrow, and its add or subtract does not overflow sixteen signed bits. The slot's result register loads even when its valid output is low.
- R7: With `pack_en` low, `vld1_o` and `nar1_o` are low on the next cycle and `res1_o` keeps its value.
- R8: A slot that is not issued keeps its result register unchanged and shows its valid output low one cycle later.
- R9: Opcodes 5 to 7 are reserved. They drive both valid outputs low one cycle later and change neither result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pack_en | input | 1 | Run two sixteen-bit operations side by side |
| op | input | 3 | Operation code, shared by both slots |
| vld0_i | input | 1 | Slot 0 issue |
| a0 | input | 32 | Slot 0 first operand |
| b0 | input | 32 | Slot 0 second operand |
| vld1_i | input | 1 | Slot 1 issue (used only when packing) |
| a1 | input | 32 | Slot 1 first operand |
| b1 | input | 32 | Slot 1 second operand |
| res0_o | output | 32 | Slot 0 result |
| res1_o | output | 32 | Slot 1 result |
| vld0_o | output | 1 | Slot 0 result valid |
| vld1_o | output | 1 | Slot 1 result valid |
| nar0_o | output | 1 | Slot 0 operands were narrow |
| nar1_o | output | 1 | Slot 1 operands were narrow |

## Verification
The bound checker watches several properties on every cycle. It checks that the upper-half input registers stay still whenever a narrow unpacked issue gates them. It checks that slot 1 goes quiet outside packed mode, that an idle slot keeps its result, that reserved opcodes produce no valid output, and that any valid narrow or packed result is a proper sign extension. Whether each value is numerically right can only be shown by the bench scenarios, which compare against reference functions. Those scenarios include a carry out of bit 15 in both gated and full-width form, carries that must stop at the slot boundary, and packed overflow forcing a reissue.

// File: rtl/narrow_alu.sv
module narrow_alu #(
  parameter int W   = 32,
  parameter int OPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pack_en,
  input  logic [OPW-1:0] op,
  input  logic           vld0_i,
  input  logic [W-1:0]   a0,
  input  logic [W-1:0]   b0,
  input  logic           vld1_i,
  input  logic [W-1:0]   a1,
  input  logic [W-1:0]   b1,
  output logic [W-1:0]   res0_o,
  output logic [W-1:0]   res1_o,
  output logic           vld0_o,
  output logic           vld1_o,
  output logic           nar0_o,
  output logic           nar1_o
);
  localparam int H = W / 2;
  localparam logic [OPW-1:0] OP_ADD = OPW'(0);
  localparam logic [OPW-1:0] OP_SUB = OPW'(1);
  localparam logic [OPW-1:0] OP_AND = OPW'(2);
  localparam logic [OPW-1:0] OP_OR  = OPW'(3);
  localparam logic [OPW-1:0] OP_XOR = OPW'(4);

  function automatic logic is_narrow(input logic [W-1:0] x);
    return (&x[W-1:H-1]) | ~(|x[W-1:H-1]);
  endfunction

  function automatic logic [H-1:0] bitwise(input logic [OPW-1:0] o,
                                           input logic [H-1:0] x,
                                           input logic [H-1:0] y);
    case (o)
      OP_AND:  return x & y;
      OP_OR:   return x | y;
      default: return x ^ y;
    endcase
  endfunction

  logic is_sub, is_arith, legal;
  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign legal    = is_arith || (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);

  logic nar_p0, nar_p1, gate;
  assign nar_p0 = is_narrow(a0) & is_narrow(b0);
  assign nar_p1 = is_narrow(a1) & is_narrow(b1);
  assign gate   = !pack_en && nar_p0;

  // low half: slot 0 in both modes
  logic [H-1:0] lo_a, lo_b, lo_bx, lo_l, lo_r;
  logic [H:0]   lo_u;
  logic         lo_ovf, lo_s;
  assign lo_a   = a0[H-1:0];
  assign lo_b   = b0[H-1:0];
  assign lo_bx  = is_sub ? ~lo_b : lo_b;
  assign lo_u   = {1'b0, lo_a} + {1'b0, lo_bx} + (H+1)'(is_sub);
  assign lo_ovf = (lo_a[H-1] == lo_bx[H-1]) && (lo_u[H-1] != lo_a[H-1]);
  assign lo_s   = is_arith ? (lo_ovf ? lo_a[H-1] : lo_u[H-1]) : lo_l[H-1];
  assign lo_l   = bitwise(op, lo_a, lo_b);
  assign lo_r   = is_arith ? lo_u[H-1:0] : lo_l;

  // upper half: slot 1 when packed, held when gated
  logic [H-1:0] hold_a, hold_b;
  logic [H-1:0] up_a, up_b, up_bx, up_u, up_l, up_r;
  logic         up_cin, up_ovf, up_load;
  assign up_a    = pack_en ? a1[H-1:0] : (gate ? hold_a : a0[W-1:H]);
  assign up_b    = pack_en ? b1[H-1:0] : (gate ? hold_b : b0[W-1:H]);
  assign up_bx   = is_sub ? ~up_b : up_b;
  assign up_cin  = pack_en ? is_sub : lo_u[H];
  assign up_u    = up_a + up_bx + H'(up_cin);
  assign up_ovf  = (up_a[H-1] == up_bx[H-1]) && (up_u[H-1] != up_a[H-1]);
  assign up_l    = bitwise(op, up_a, up_b);
  assign up_r    = is_arith ? up_u : up_l;
  assign up_load = (pack_en ? vld1_i : vld0_i) && !gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
    end else if (up_load) begin
      hold_a <= up_a;
      hold_b <= up_b;
    end
  end

  logic [W-1:0] r0_full, r0_pack, r1_pack;
  assign r0_full = gate ? {{H{lo_s}}, lo_r} : {up_r, lo_r};
  assign r0_pack = {{H{lo_r[H-1]}}, lo_r};
  assign r1_pack = {{H{up_r[H-1]}}, up_r};

  logic ld0, ld1, ok0, ok1;
  assign ld0 = vld0_i && legal;
  assign ld1 = pack_en && vld1_i && legal;
  assign ok0 = !pack_en || (nar_p0 && !(is_arith && lo_ovf));
  assign ok1 = nar_p1 && !(is_arith && up_ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res0_o <= '0;
      res1_o <= '0;
      vld0_o <= 1'b0;
      vld1_o <= 1'b0;
      nar0_o <= 1'b0;
      nar1_o <= 1'b0;
    end else begin
      if (ld0) res0_o <= pack_en ? r0_pack : r0_full;
      if (ld1) res1_o <= r1_pack;
      vld0_o <= ld0 && ok0;
      vld1_o <= ld1 && ok1;
      nar0_o <= vld0_i && nar_p0;
      nar1_o <= pack_en && vld1_i && nar_p1;
    end
  end
endmodule

// File: rtl/narrow_alu_chk.sv
module narrow_alu_chk #(
  parameter int W   = 32,
  parameter int OPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pack_en,
  input logic [OPW-1:0] op,
  input logic           vld0_i,
  input logic           gate,
  input logic [W/2-1:0] hold_a,
  input logic [W/2-1:0] hold_b,
  input logic [W-1:0]   res0_o,
  input logic [W-1:0]   res1_o,
  input logic           vld0_o,
  input logic           vld1_o,
  input logic           nar0_o,
  input logic           nar1_o
);
  localparam int H = W / 2;

  p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> ($stable(hold_a) && $stable(hold_b)));

  p_slot1_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pack_en |=> (!vld1_o && !nar1_o && $stable(res1_o)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld0_i |=> (!vld0_o && $stable(res0_o)));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op > OPW'(4)) |=> (!vld0_o && !vld1_o && $stable(res0_o) && $stable(res1_o)));

  p_narrow_sext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld0_o && nar0_o) |-> (res0_o[W-1:H+1] == {(H-1){res0_o[H]}}));

  p_packed_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld1_o |-> (res1_o[W-1:H] == {H{res1_o[H-1]}}));
endmodule

bind narrow_alu narrow_alu_chk #(.W(W), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pack_en(pack_en), .op(op), .vld0_i(vld0_i),
  .gate(gate), .hold_a(hold_a), .hold_b(hold_b),
  .res0_o(res0_o), .res1_o(res1_o), .vld0_o(vld0_o), .vld1_o(vld1_o),
  .nar0_o(nar0_o), .nar1_o(nar1_o)
);

// File: tb/narrow_alu_tb.sv
`timescale 1ns/1ps
module narrow_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pack_en = 1'b0;
  logic [2:0]  op = '0;
  logic        vld0_i = 1'b0, vld1_i = 1'b0;
  logic [31:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
  logic [31:0] res0_o, res1_o;
  logic        vld0_o, vld1_o, nar0_o, nar1_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] e_r0 = '0, e_r1 = '0;
  logic        e_v0 = 0, e_v1 = 0, e_n0 = 0, e_n1 = 0;

  always #5 clk = ~clk;

  narrow_alu u_dut (
    .clk(clk), .rst_n(rst_n), .pack_en(pack_en), .op(op),
    .vld0_i(vld0_i), .a0(a0), .b0(b0), .vld1_i(vld1_i), .a1(a1), .b1(b1),
    .res0_o(res0_o), .res1_o(res1_o), .vld0_o(vld0_o), .vld1_o(vld1_o),
    .nar0_o(nar0_o), .nar1_o(nar1_o)
  );

  function automatic bit f_nar(input logic [31:0] x);
    return (x[31:15] == 17'h0) || (x[31:15] == 17'h1ffff);
  endfunction

  function automatic logic [31:0] f_alu32(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      default: return x ^ y;
    endcase
  endfunction

  function automatic logic [16:0] f_alu17(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y);
    logic [16:0] sx, sy;
    sx = {x[15], x};
    sy = {y[15], y};
    case (o)
      3'd0: return sx + sy;
      3'd1: return sx - sy;
      3'd2: return sx & sy;
      3'd3: return sx | sy;
      default: return sx ^ sy;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " res0"}, res0_o, e_r0);
    chk({tag, " flags0"}, {30'd0, vld0_o, nar0_o}, {30'd0, e_v0, e_n0});
    chk({tag, " res1"}, res1_o, e_r1);
    chk({tag, " flags1"}, {30'd0, vld1_o, nar1_o}, {30'd0, e_v1, e_n1});
  endtask

  task automatic step(input bit pk, input logic [2:0] o,
                      input bit v0, input logic [31:0] x0, input logic [31:0] y0,
                      input bit v1, input logic [31:0] x1, input logic [31:0] y1,
                      input string tag);
    logic [16:0] q0, q1;
    bit legal;
    @(negedge clk);
    pack_en = pk; op = o; vld0_i = v0; a0 = x0; b0 = y0; vld1_i = v1; a1 = x1; b1 = y1;
    legal = (o <= 3'd4);
    q0 = f_alu17(o, x0[15:0], y0[15:0]);
    q1 = f_alu17(o, x1[15:0], y1[15:0]);
    if (!pk) begin
      if (v0 && legal) e_r0 = f_alu32(o, x0, y0);
      e_v0 = v0 && legal;
      e_v1 = 0;
      e_n0 = v0 && f_nar(x0) && f_nar(y0);
      e_n1 = 0;
    end else begin
      if (v0 && legal) e_r0 = {{16{q0[15]}}, q0[15:0]};
      if (v1 && legal) e_r1 = {{16{q1[15]}}, q1[15:0]};
      e_v0 = v0 && legal && f_nar(x0) && f_nar(y0) && (q0[16] == q0[15]);
      e_v1 = v1 && legal && f_nar(x1) && f_nar(y1) && (q1[16] == q1[15]);
      e_n0 = v0 && f_nar(x0) && f_nar(y0);
      e_n1 = v1 && f_nar(x1) && f_nar(y1);
    end
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  function automatic logic [31:0] rnd_opnd();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 4)
      0: return {{17{r[15]}}, r[14:0]};
      1: return {{17{1'b0}}, r[14:0]};
      2: return (r[0] ? 32'h0000_7fff : 32'hffff_8000);
      default: return r;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(posedge clk);
    #2;
    compare("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    compare("R1 after reset");

    step(0, 3'd0, 1, 32'h0001_ffff, 32'h0000_0001, 0, 0, 0, "R3 wide add carry");
    step(0, 3'd1, 1, 32'h1234_0000, 32'h0000_0001, 0, 0, 0, "R3 wide sub borrow");
    step(0, 3'd4, 1, 32'hf0f0_1234, 32'h0ff0_ffff, 0, 0, 0, "R3 xor");
    step(0, 3'd2, 1, 32'h8000_1234, 32'h0000_7fff, 0, 0, 0, "R2 wide operand flag");
    step(0, 3'd0, 1, 32'h0000_7fff, 32'h0000_0001, 0, 0, 0, "R4 gated add into bit16");
    step(0, 3'd1, 1, 32'hffff_8000, 32'h0000_0001, 0, 0, 0, "R4 gated sub borrow");
    step(0, 3'd0, 1, 32'hffff_8000, 32'hffff_8000, 0, 0, 0, "R4 gated neg overflow");
    step(0, 3'd3, 1, 32'hffff_9000, 32'h0000_0003, 0, 0, 0, "R4 gated or");
    step(1, 3'd0, 1, 32'h0000_0005, 32'h0000_0003, 1, 32'hffff_fffe, 32'hffff_fffd, "R5 packed add");
    step(1, 3'd0, 1, 32'hffff_ffff, 32'h0000_0001, 1, 32'h0000_0001, 32'h0000_0001, "R5 split carry");
    step(1, 3'd1, 1, 32'h0000_0000, 32'h0000_0001, 1, 32'h0000_0010, 32'h0000_0020, "R5 packed sub");
    step(1, 3'd0, 1, 32'h0000_1000, 32'h0000_0001, 1, 32'h0000_7fff, 32'h0000_0001, "R6 slot1 overflow");
    step(1, 3'd2, 1, 32'h0001_0000, 32'h0000_0000, 1, 32'h0000_00ff, 32'hffff_f00f, "R6 wide slot0");
    step(0, 3'd0, 1, 32'h0000_0002, 32'h0000_0002, 1, 32'h0000_0009, 32'h0000_0009, "R7 unpacked slot1 idle");
    step(0, 3'd0, 0, 32'h5555_5555, 32'h1111_1111, 0, 0, 0, "R8 idle slot0");
    step(1, 3'd0, 0, 32'h0000_0001, 32'h0000_0001, 0, 32'h0000_0004, 32'h0000_0004, "R8 idle both packed");
    step(0, 3'd6, 1, 32'h0000_0007, 32'h0000_0001, 0, 0, 0, "R9 reserved unpacked");
    step(1, 3'd5, 1, 32'h0000_0007, 32'h0000_0001, 1, 32'h0000_0002, 32'h0000_0003, "R9 reserved packed");

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 3) == 0, 3'($urandom % 8), ($urandom % 8) != 0,
           rnd_opnd(), rnd_opnd(), ($urandom % 4) != 0, rnd_opnd(), rnd_opnd(),
           "R2 R3 R5 R6 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule